// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block gathers single-cycle event pulses from the internal sources of a power-management device and reports them through one active-low interrupt pin. Each event sets a pending bit in one of five 16-bit secondary status registers. Each status register has its own 16-bit mask register. A primary summary register has one bit per source group and shows which groups hold unmasked pending work. A top-level mask register decides which of those summary bits may drive the pin.

Software reaches all registers through a synchronous read/write port. A read returns its data one cycle after the request. Pending bits are cleared by writing ones to them. The undervoltage summary bit covers pending bits in two different status registers. Touch pen-down and touch-data events each have a summary bit of their own. A configuration bit selects the pin style:
- Open-drain: the pin is pulled low when active and released otherwise.
- Push-pull: the pin is always driven.

Top module: `irqh_top`

Register addresses (5-bit):
- Status register k (k = 1..5) is at 0x00+k-1.
- Mask register k is at 0x08+k-1.
- The primary summary register is at 0x10 and is read-only.
- The top-level mask register is at 0x11.
- The configuration register is at 0x12; bit 0 = 1 selects push-pull.

Event pulse lines: register k takes `evt_i[(k-1)*16 +: 16]`.

## Requirements
- R1: After reset, every status register reads 0x0000. Every secondary mask register and the top-level mask read 0xFFFF. The primary register and the configuration register read 0x0000. The pin is released: `irq_oe_o`=0 and `irq_pin_o`=0.
- R2: An event pulse on a defined source position sets its status bit whether or not that bit is masked. The defined positions are:
  - register 1: bits 0–14
  - register 2: bits 0–9
  - register 3: bits 0–9
  - register 4: bits 0–3 and 8–9
  - register 5: bits 0–15

  Events on any other position are ignored, and that status bit stays 0.
- R3: Writing a status register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: An event that arrives in the same cycle as a write-one-to-clear of its own bit leaves that bit set.
- R5: A primary bit reads 1 when any pending, unmasked status bit of its group is set. The groups are:
  - bit 0: temperature (reg1 bit 0)
  - bit 1: on-pin (reg1 bit 1)
  - bit 2: power path (reg1 bits 2–4)
  - bit 3: watchdog (reg1 bit 5)
  - bit 4: clock/alarm (reg1 bits 6–7)
  - bit 7: ADC (reg1 bits 10–14)
  - bit 8: charger (reg2 bits 0–7)
  - bit 9: current sink (reg2 bits 8–9)
  - bit 11: high current (reg4 bits 8–9)
  - bit 12: GPIO (reg5 all bits)
- R6: Primary bit 10 (undervoltage) is set by any pending, unmasked bit in reg3 bits 0–9 or in reg4 bits 0–3.
- R7: Touch pen-down (reg1 bit 8) drives primary bit 5 alone. Touch data (reg1 bit 9) drives primary bit 6 alone.
- R8: The pin is active only while some primary bit is set whose top-level mask bit is 0.
- R9: In open-drain style (config bit 0 = 0), an active pin gives `irq_oe_o`=1 and `irq_pin_o`=0, and an inactive pin is released (`irq_oe_o`=0). In push-pull style, `irq_oe_o`=1 at all times and `irq_pin_o` equals the inverse of active.
- R10: The pin stays active until every contributing status bit has been cleared or masked. The pin changes in the cycle after the write that clears or masks the last such bit.
- R11: `rdata_o` holds the read result in the cycle after `rd_en_i` is sampled. Reads of unassigned addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 80 | Event pulses, 16 per status register |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after the read |
| irq_pin_o | output | 1 | Pin level, low means interrupt |
| irq_oe_o | output | 1 | Pin drive enable |

## Verification
The assertions assume that events are single-cycle pulses sampled at the clock edge. They also assume that a read and a write are never requested in the same cycle. Status bits are therefore expected to rise only where the previous cycle carried an event.

The stimulus changes every input on the falling edge and holds each pulse for one cycle. It issues each read or write in its own cycle. The only deliberate overlap between a write and an event is the collision case on the same bit.

// File: rtl/irqh_pkg.sv
package irqh_pkg;
  parameter int NUM_REG  = 5;
  parameter int REG_W    = 16;
  parameter int NUM_GRP  = 13;
  parameter int GRP_W    = 4;
  parameter int ADDR_W   = 5;
  localparam int EVT_W   = NUM_REG * REG_W;
  localparam logic [GRP_W-1:0] GRP_NONE = '1;

  localparam logic [ADDR_W-1:0] A_STAT0 = 5'h00;
  localparam logic [ADDR_W-1:0] A_MASK0 = 5'h08;
  localparam logic [ADDR_W-1:0] A_PRIM  = 5'h10;
  localparam logic [ADDR_W-1:0] A_TOPM  = 5'h11;
  localparam logic [ADDR_W-1:0] A_CFG   = 5'h12;

  // Summary group that owns status bit b of register r (0-based).
  function automatic logic [GRP_W-1:0] grp_of(int r, int b);
    logic [GRP_W-1:0] g;
    g = GRP_NONE;
    case (r)
      0: begin
        if (b == 0) g = 4'd0;
        else if (b == 1) g = 4'd1;
        else if (b >= 2 && b <= 4) g = 4'd2;
        else if (b == 5) g = 4'd3;
        else if (b == 6 || b == 7) g = 4'd4;
        else if (b == 8) g = 4'd5;
        else if (b == 9) g = 4'd6;
        else if (b >= 10 && b <= 14) g = 4'd7;
      end
      1: begin
        if (b <= 7) g = 4'd8;
        else if (b <= 9) g = 4'd9;
      end
      2: if (b <= 9) g = 4'd10;
      3: begin
        if (b <= 3) g = 4'd10;
        else if (b == 8 || b == 9) g = 4'd11;
      end
      4: g = 4'd12;
      default: g = GRP_NONE;
    endcase
    return g;
  endfunction

  // Positions of a register that carry a defined source.
  function automatic logic [REG_W-1:0] valid_bits(int r);
    logic [REG_W-1:0] v;
    for (int b = 0; b < REG_W; b++) v[b] = (grp_of(r, b) != GRP_NONE);
    return v;
  endfunction
endpackage

// File: rtl/irqh_status_bank.sv
module irqh_status_bank
  import irqh_pkg::*;
#(
  parameter int REG_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] evt_i,
  input  logic             clr_we_i,
  input  logic             mask_we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] mask_o,
  output logic [REG_W-1:0] pend_o
);
  localparam logic [REG_W-1:0] VALID = valid_bits(REG_IDX);

  logic [REG_W-1:0] evt_v;
  logic [REG_W-1:0] clr_v;

  assign evt_v  = evt_i & VALID;
  assign clr_v  = clr_we_i ? wdata_i : '0;
  assign pend_o = status_o & ~mask_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_o <= '0;
      mask_o   <= '1;
    end else begin
      status_o <= (status_o & ~clr_v) | evt_v;
      if (mask_we_i) mask_o <= wdata_i;
    end
  end

  // R2: a status bit only rises where an event was seen
  assert_rise_needs_evt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o & ~$past(status_o)) & ~$past(evt_i & VALID)) == '0);

  // R3: a cleared bit with no event is zero afterwards
  assert_clear_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> (status_o & $past(wdata_i & ~evt_i)) == '0);

  // R4: an accepted event is never lost, even against a clear
  assert_evt_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & VALID) != '0) |=> ((status_o & $past(evt_i & VALID)) == $past(evt_i & VALID)));
endmodule

// File: rtl/irqh_summary.sv
module irqh_summary
  import irqh_pkg::*;
(
  input  logic [EVT_W-1:0] pend_i,
  output logic [REG_W-1:0] primary_o
);
  always_comb begin
    primary_o = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      for (int r = 0; r < NUM_REG; r++) begin
        for (int b = 0; b < REG_W; b++) begin
          if (grp_of(r, b) == GRP_W'(g))
            primary_o[g] = primary_o[g] | pend_i[r*REG_W + b];
        end
      end
    end
  end
endmodule

// File: rtl/irqh_pin_drv.sv
module irqh_pin_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic push_pull_i,
  output logic pin_o,
  output logic oe_o
);
  assign oe_o  = push_pull_i | active_i;
  assign pin_o = push_pull_i & ~active_i;

  // R9: open-drain style never drives the pin high
  assert_od_no_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !push_pull_i |-> !(oe_o && pin_o));

  // R9: push-pull style always drives
  assert_pp_drives_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push_pull_i |-> oe_o);
endmodule

// File: rtl/irqh_top.sv
module irqh_top
  import irqh_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_pin_o,
  output logic              irq_oe_o
);
  logic [EVT_W-1:0] status_all;
  logic [EVT_W-1:0] mask_all;
  logic [EVT_W-1:0] pend_all;
  logic [REG_W-1:0] primary;
  logic [REG_W-1:0] top_mask;
  logic             push_pull;
  logic             irq_active;
  logic [REG_W-1:0] rd_mux;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_bank
    logic clr_we;
    logic mask_we;
    assign clr_we  = wr_en_i && (addr_i == A_STAT0 + ADDR_W'(r));
    assign mask_we = wr_en_i && (addr_i == A_MASK0 + ADDR_W'(r));
    irqh_status_bank #(.REG_IDX(r)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i[r*REG_W +: REG_W]),
      .clr_we_i (clr_we),
      .mask_we_i(mask_we),
      .wdata_i  (wdata_i),
      .status_o (status_all[r*REG_W +: REG_W]),
      .mask_o   (mask_all[r*REG_W +: REG_W]),
      .pend_o   (pend_all[r*REG_W +: REG_W])
    );
  end

  irqh_summary u_summary (
    .pend_i   (pend_all),
    .primary_o(primary)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_mask  <= '1;
      push_pull <= 1'b0;
    end else if (wr_en_i) begin
      if (addr_i == A_TOPM) top_mask <= wdata_i;
      if (addr_i == A_CFG) push_pull <= wdata_i[0];
    end
  end

  assign irq_active = |(primary & ~top_mask);

  irqh_pin_drv u_pin (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (irq_active),
    .push_pull_i(push_pull),
    .pin_o      (irq_pin_o),
    .oe_o       (irq_oe_o)
  );

  always_comb begin
    rd_mux = '0;
    for (int r = 0; r < NUM_REG; r++) begin
      if (addr_i == A_STAT0 + ADDR_W'(r)) rd_mux = status_all[r*REG_W +: REG_W];
      if (addr_i == A_MASK0 + ADDR_W'(r)) rd_mux = mask_all[r*REG_W +: REG_W];
    end
    if (addr_i == A_PRIM) rd_mux = primary;
    if (addr_i == A_TOPM) rd_mux = top_mask;
    if (addr_i == A_CFG)  rd_mux = {{(REG_W-1){1'b0}}, push_pull};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  // R10: an active pin is always backed by a pending unmasked status bit
  assert_pin_backed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_oe_o && !irq_pin_o) |-> (pend_all != '0));

  // R11: a summary read returns the summary seen at the request
  assert_read_prim_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == A_PRIM) |=> (rdata_o == $past(primary)));
endmodule

// File: tb/irqh_top_bench.sv
module irqh_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [79:0] evt = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pin;
  logic        oe;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  irqh_top u_irqh_top (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_pin_o(pin), .irq_oe_o(oe)
  );

  // monitor: pops expected read data as results appear
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty: actual %h expected none", rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s: read actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic rd(input logic [4:0] a, input logic [15:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int idx);
    evt[idx] = 1'b1;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic chk_pin(input logic e_oe, input logic e_pin, input string t);
    n_cmp++;
    if (oe !== e_oe || (e_oe && pin !== e_pin)) begin
      n_bad++;
      $display("FAIL %s: pin actual oe=%b pin=%b expected oe=%b pin=%b", t, oe, pin, e_oe, e_pin);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int k = 0; k < 5; k++) rd(5'(k), 16'h0000, "R1 status");
    for (int k = 0; k < 5; k++) rd(5'(8 + k), 16'hFFFF, "R1 mask");
    rd(5'h10, 16'h0000, "R1 primary");
    rd(5'h11, 16'hFFFF, "R1 top mask");
    rd(5'h12, 16'h0000, "R1 config");
    chk_pin(1'b0, 1'b0, "R1 pin");
    rd(5'h1F, 16'h0000, "R11 unassigned");

    // R2 latch while masked
    pulse(0);
    rd(5'h00, 16'h0001, "R2 masked latch");
    rd(5'h10, 16'h0000, "R5 masked no primary");
    wr(5'h08, 16'hFFFE);
    rd(5'h10, 16'h0001, "R5 temperature group");
    chk_pin(1'b0, 1'b0, "R8 top mask blocks");
    wr(5'h11, 16'h0000);
    chk_pin(1'b1, 1'b0, "R8 pin active");

    // R3 write-one-to-clear
    wr(5'h00, 16'h0000);
    rd(5'h00, 16'h0001, "R3 zero write keeps");
    wr(5'h00, 16'h0001);
    rd(5'h00, 16'h0000, "R3 one write clears");
    chk_pin(1'b0, 1'b0, "R10 released after clear");

    // R10 two contributors
    wr(5'h0A, 16'hFFFE);
    pulse(0); pulse(32);
    chk_pin(1'b1, 1'b0, "R10 two pending");
    wr(5'h02, 16'h0001);
    chk_pin(1'b1, 1'b0, "R10 one still pending");
    wr(5'h00, 16'h0001);
    chk_pin(1'b0, 1'b0, "R10 all cleared");
    pulse(0);
    chk_pin(1'b1, 1'b0, "R10 pending again");
    wr(5'h08, 16'hFFFF);
    chk_pin(1'b0, 1'b0, "R10 masked releases");
    rd(5'h00, 16'h0001, "R2 mask keeps status");
    wr(5'h00, 16'h0001);

    // R6 undervoltage across registers
    wr(5'h0B, 16'hFFFD);
    pulse(49);
    rd(5'h03, 16'h0002, "R6 reg4 status");
    rd(5'h10, 16'h0400, "R6 from reg4");
    wr(5'h03, 16'h0002);
    pulse(32);
    rd(5'h10, 16'h0400, "R6 from reg3");
    wr(5'h02, 16'h0001);
    rd(5'h10, 16'h0000, "R6 cleared");

    // R7 touch bits
    wr(5'h08, 16'hFCFF);
    pulse(8);
    rd(5'h10, 16'h0020, "R7 pen-down");
    wr(5'h00, 16'h0100);
    pulse(9);
    rd(5'h10, 16'h0040, "R7 data");
    wr(5'h00, 16'h0200);

    // R5 gpio and charger
    wr(5'h0C, 16'h7FFF);
    pulse(79);
    rd(5'h10, 16'h1000, "R5 gpio group");
    wr(5'h04, 16'h8000);
    wr(5'h09, 16'hFFFE);
    pulse(16);
    rd(5'h10, 16'h0100, "R5 charger group");
    wr(5'h01, 16'h0001);

    // R4 event meets clear
    evt[0] = 1'b1; wr_en = 1'b1; addr = 5'h00; wdata = 16'h0001;
    @(negedge clk);
    evt = '0; wr_en = 1'b0;
    rd(5'h00, 16'h0001, "R4 collision kept");
    wr(5'h00, 16'h0001);
    rd(5'h00, 16'h0000, "R4 later clear");

    // R2 undefined position
    pulse(63);
    rd(5'h03, 16'h0000, "R2 undefined ignored");

    // R9 push-pull
    wr(5'h12, 16'h0001);
    chk_pin(1'b1, 1'b1, "R9 pp idle high");
    pulse(8);
    chk_pin(1'b1, 1'b0, "R9 pp active low");
    wr(5'h00, 16'h0100);
    chk_pin(1'b1, 1'b1, "R9 pp idle again");
    wr(5'h12, 16'h0000);
    chk_pin(1'b0, 1'b0, "R9 od released");

    // R8 top mask one bit
    wr(5'h11, 16'h0020);
    pulse(8);
    rd(5'h10, 16'h0020, "R8 primary set");
    chk_pin(1'b0, 1'b0, "R8 bit masked at top");
    wr(5'h00, 16'h0100);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule